// File: doc/BRIEF.md
# I/O MMU Context Register Bank

This block holds the software-visible state of a small I/O memory management unit that serves four translation contexts. Each context has its own window of registers: a control word, a table-control word, a bus-control word, two table base pairs, two memory-attribute words, a fault status word and a fault address word. A plain 32-bit register port gives access to all of them. The whole bank also answers at a second, aliased base.

The translation engine reports faults through a one-cycle fault strobe that carries the context, the status bits and the input address. The block captures the first fault, merges the flags of later faults, and drives a per-context and a combined level interrupt. Software starts a full TLB invalidation of a context by setting the flush bit. That bit drives an invalidate request to the TLB and stays set until the TLB returns a one-cycle done pulse. Software learns of completion by polling the bit. Fault status is cleared by writing the value zero, and clearing it also clears the captured address.

Top module: `xlat_ctx_regbank`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and `irq`, `ctx_irq` and `inv_req` are all 0.
- R2: Address bits 7:6 select the context (window of 0x40 bytes) and bits 5:2 select the word. Bit 11 is ignored, so the alias at +0x800 reaches the same registers. A read returns 0 in three cases: any of bits 10:8 is set, bits 1:0 are nonzero, or the word offset is unused. A write in any of those cases has no effect.
- R3: The control word at offset 0x00 keeps bits 0, 2, 3, 5:4, 16 and 17 as written, and its other bits read 0. Bit 1 reads the flush state.
- R4: Writing the control word with bit 1 set raises `inv_req[c]`, and bit 1 reads 1 from the next cycle. Both stay set, including across control writes that have bit 1 clear, until a cycle with `inv_done[c]` high. After that cycle both read 0.
- R5: If `inv_done[c]` and a control write with bit 1 set fall in the same cycle, the flush stays pending.
- R6: A fault strobe to a context whose status is 0 loads status with the strobe's bits 0,1,2,4 (flags), 10:8 (error code) and 13:12 (level), and loads the fault address word (offset 0x30) with `flt_addr`. A strobe whose flag bits 0,1,2,4 are all 0 is ignored.
- R7: A fault strobe to a context whose status is nonzero ORs its flag bits 0,1,2,4 into status. The error code, the level and the captured address are left unchanged.
- R8: Writing 0 to the status word (offset 0x20) clears status and the fault address. A nonzero write to it has no effect. If a zero write and a fault strobe land in the same cycle, the fault is captured as in R6.
- R9: `ctx_irq[c]` is high exactly when control bit 2 is set and any status flag bit 0,1,2,4 is set. `irq` is the OR of `ctx_irq`.
- R10: Offsets 0x08, 0x0C, 0x10, 0x18, 0x28 and 0x2C hold 32 bits. The upper base words at 0x14 and 0x1C hold bits 7:0 only, giving a 40-bit base. The fault address word is read-only.
- R11: Writing the value 0x2 to the control word disables the context (bit 0 reads 0) and starts an invalidation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| flt_valid | input | 1 | One-cycle fault strobe from the translation engine |
| flt_ctx | input | 2 | Context of the fault |
| flt_status | input | 32 | Fault status bits, in the same layout as the status word |
| flt_addr | input | 32 | Input address that faulted |
| inv_done | input | 4 | Per-context invalidation-complete pulse |
| inv_req | output | 4 | Per-context TLB invalidate request (level) |
| ctx_irq | output | 4 | Per-context interrupt |
| irq | output | 1 | Combined level interrupt |

## Verification
Two pairs of events can arrive in the same cycle. A flush write can meet the done pulse of the invalidation already pending, and a zero write to the status word can meet a new fault strobe. The bench forces both pairs in directed steps. It also lets them collide freely under random stimulus that drives write, fault and done together. After every cycle it compares the read data, the invalidate requests and the interrupts against a model updated by the requirement rules. A collision passes when the flush stays pending and the fresh fault, with its address, is the one held.

// File: rtl/xlat_pkg.sv
// Shared constants for the I/O MMU context register bank.
// Assumes 32-bit registers, four-byte word addressing and 0x40-byte context windows.
package xlat_pkg;
    localparam int DATA_W     = 32;
    localparam int WIDX_W     = 4;       // 16 words per 0x40-byte window
    localparam int CTX_SHIFT  = 6;
    typedef logic [WIDX_W-1:0] widx_t;

    localparam widx_t W_CTL  = 4'd0;
    localparam widx_t W_TTC  = 4'd2;
    localparam widx_t W_BUS  = 4'd3;
    localparam widx_t W_B0L  = 4'd4;
    localparam widx_t W_B0H  = 4'd5;
    localparam widx_t W_B1L  = 4'd6;
    localparam widx_t W_B1H  = 4'd7;
    localparam widx_t W_STS  = 4'd8;
    localparam widx_t W_AT0  = 4'd10;
    localparam widx_t W_AT1  = 4'd11;
    localparam widx_t W_FAR  = 4'd12;

    localparam logic [DATA_W-1:0] CTL_KEEP  = 32'h0003_003D; // flush bit kept apart
    localparam logic [DATA_W-1:0] STS_KEEP  = 32'h0000_3717;
    localparam logic [DATA_W-1:0] FLAG_KEEP = 32'h0000_0017;
    localparam logic [DATA_W-1:0] HI_KEEP   = 32'h0000_00FF;
    localparam int               FLUSH_BIT = 1;
    localparam int               IEN_BIT   = 2;
endpackage

// File: rtl/xlat_addr_dec.sv
// Address decoder: splits a byte address into context, word index and a hit flag.
// Assumes the top address bit selects the alias bank and is ignored.
module xlat_addr_dec
    import xlat_pkg::*;
#(
    parameter int N_CTX  = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]                addr,
    output logic                             hit,
    output logic [$clog2(N_CTX)-1:0]         ctx_sel,
    output widx_t                            widx
);
    localparam int CTX_BITS  = $clog2(N_CTX);
    localparam int HOLE_LO   = CTX_SHIFT + CTX_BITS;
    localparam int ALIAS_BIT = ADDR_W - 1;

    wire unused_alias = addr[ALIAS_BIT];

    // Decode the context window, the word and whether the address is mapped.
    always_comb begin
        ctx_sel = addr[CTX_SHIFT +: CTX_BITS];
        widx    = addr[2 +: WIDX_W];
        hit     = (addr[ALIAS_BIT-1:HOLE_LO] == '0) && (addr[1:0] == 2'b00);
    end
endmodule

// File: rtl/xlat_ctx_slice.sv
// One context's registers: control with flush tracking, table and attribute words,
// fault status capture and fault address latch.
// Assumes wr_en is already qualified by address hit and context select.
module xlat_ctx_slice
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  widx_t             widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flt_v,
    input  logic [DATA_W-1:0] flt_status,
    input  logic [DATA_W-1:0] flt_addr,
    input  logic              inv_done,
    output logic [DATA_W-1:0] rd_word,
    output logic              ctx_irq,
    output logic              inv_req
);
    logic [DATA_W-1:0] ctl_q, ttc_q, bus_q, b0l_q, b0h_q, b1l_q, b1h_q, at0_q, at1_q;
    logic [DATA_W-1:0] sts_q, far_q;
    logic              flush_q;
    logic              wr_ctl, clr_w, flt_w;
    logic [DATA_W-1:0] flt_flags;

    // Qualify the individual write and capture events.
    always_comb begin
        wr_ctl    = wr_en && (widx == W_CTL);
        clr_w     = wr_en && (widx == W_STS) && (wdata == '0);
        flt_flags = flt_status & FLAG_KEEP;
        flt_w     = flt_v && (flt_flags != '0);
    end

    // Configuration words written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0; ttc_q <= '0; bus_q <= '0; b0l_q <= '0; b0h_q <= '0;
            b1l_q <= '0; b1h_q <= '0; at0_q <= '0; at1_q <= '0;
        end else if (wr_en) begin
            case (widx)
                W_CTL:   ctl_q <= wdata & CTL_KEEP;
                W_TTC:   ttc_q <= wdata;
                W_BUS:   bus_q <= wdata;
                W_B0L:   b0l_q <= wdata;
                W_B0H:   b0h_q <= wdata & HI_KEEP;
                W_B1L:   b1l_q <= wdata;
                W_B1H:   b1h_q <= wdata & HI_KEEP;
                W_AT0:   at0_q <= wdata;
                W_AT1:   at1_q <= wdata;
                default: ;
            endcase
        end
    end

    // Flush bit: set by a control write, cleared by done unless re-armed the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flush_q <= 1'b0;
        else if (wr_ctl && wdata[FLUSH_BIT]) flush_q <= 1'b1;
        else if (inv_done)                   flush_q <= 1'b0;
    end

    // Fault capture: first fault loads all, later ones merge flags, zero write clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            far_q <= '0;
        end else if (flt_w) begin
            if (sts_q == '0 || clr_w) begin
                sts_q <= flt_status & STS_KEEP;
                far_q <= flt_addr;
            end else begin
                sts_q <= sts_q | flt_flags;
            end
        end else if (clr_w) begin
            sts_q <= '0;
            far_q <= '0;
        end
    end

    // Read mux for the selected word.
    always_comb begin
        case (widx)
            W_CTL:   rd_word = {ctl_q[DATA_W-1:FLUSH_BIT+1], flush_q, ctl_q[FLUSH_BIT-1:0]};
            W_TTC:   rd_word = ttc_q;
            W_BUS:   rd_word = bus_q;
            W_B0L:   rd_word = b0l_q;
            W_B0H:   rd_word = b0h_q;
            W_B1L:   rd_word = b1l_q;
            W_B1H:   rd_word = b1h_q;
            W_STS:   rd_word = sts_q;
            W_AT0:   rd_word = at0_q;
            W_AT1:   rd_word = at1_q;
            W_FAR:   rd_word = far_q;
            default: rd_word = '0;
        endcase
    end

    // Outputs to the TLB and the interrupt tree.
    always_comb begin
        inv_req = flush_q;
        ctx_irq = ctl_q[IEN_BIT] && ((sts_q & FLAG_KEEP) != '0);
    end

    p_flush_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !inv_done) |=> inv_req);
    p_flush_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && wdata[FLUSH_BIT]) |=> inv_req);
    p_far_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q != '0 && !clr_w) |=> $stable(far_q));
    p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q != '0 && !clr_w) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
    p_far_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q == '0) |-> (far_q == '0));
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_irq |-> ctl_q[IEN_BIT]);
endmodule

// File: rtl/xlat_ctx_regbank.sv
// Register bank top: decodes the register port, fans events out to one slice per
// context and merges read data and interrupts.
// Assumes reads are combinational from addr and writes take effect at the next edge.
module xlat_ctx_regbank
    import xlat_pkg::*;
#(
    parameter int N_CTX  = 4,
    parameter int ADDR_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     flt_valid,
    input  logic [$clog2(N_CTX)-1:0] flt_ctx,
    input  logic [DATA_W-1:0]        flt_status,
    input  logic [DATA_W-1:0]        flt_addr,
    input  logic [N_CTX-1:0]         inv_done,
    output logic [N_CTX-1:0]         inv_req,
    output logic [N_CTX-1:0]         ctx_irq,
    output logic                     irq
);
    localparam int CTX_BITS = $clog2(N_CTX);

    logic                hit;
    logic [CTX_BITS-1:0] ctx_sel;
    widx_t               widx;
    logic [DATA_W-1:0]   rd_arr [N_CTX];

    xlat_addr_dec #(.N_CTX(N_CTX), .ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .hit     (hit),
        .ctx_sel (ctx_sel),
        .widx    (widx)
    );

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        xlat_ctx_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_en && hit && (ctx_sel == CTX_BITS'(c))),
            .widx       (widx),
            .wdata      (wdata),
            .flt_v      (flt_valid && (flt_ctx == CTX_BITS'(c))),
            .flt_status (flt_status),
            .flt_addr   (flt_addr),
            .inv_done   (inv_done[c]),
            .rd_word    (rd_arr[c]),
            .ctx_irq    (ctx_irq[c]),
            .inv_req    (inv_req[c])
        );
    end

    // Merge read data and the combined interrupt.
    always_comb begin
        rdata = hit ? rd_arr[ctx_sel] : '0;
        irq   = |ctx_irq;
    end

    p_unmapped_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> ($stable(inv_req) || $past(inv_done) != '0));
endmodule

// File: tb/sim_xlat_ctx_regbank.sv
`timescale 1ns/100ps
module sim_xlat_ctx_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_ctx = '0;
    logic [31:0] flt_status = '0;
    logic [31:0] flt_addr = '0;
    logic [3:0]  inv_done = '0;
    logic [3:0]  inv_req, ctx_irq;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_reg [4][16];
    logic        m_flush [4];

    always #2.5 clk = ~clk;

    xlat_ctx_regbank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .flt_valid(flt_valid), .flt_ctx(flt_ctx),
        .flt_status(flt_status), .flt_addr(flt_addr), .inv_done(inv_done),
        .inv_req(inv_req), .ctx_irq(ctx_irq), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [1:0] c;
        logic [3:0] w;
        c = a[7:6];
        w = a[5:2];
        if (a[10:8] != 0 || a[1:0] != 0) return 32'h0;
        case (w)
            4'd0: return m_reg[c][0] | (32'(m_flush[c]) << 1);
            4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11, 4'd12: return m_reg[c][w];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_cirq();
        logic [3:0] v;
        for (int c = 0; c < 4; c++)
            v[c] = m_reg[c][0][2] && ((m_reg[c][8] & 32'h17) != 0);
        return v;
    endfunction

    function automatic logic [3:0] exp_inv();
        logic [3:0] v;
        for (int c = 0; c < 4; c++) v[c] = m_flush[c];
        return v;
    endfunction

    task automatic model_update(input bit dw, input logic [11:0] a, input logic [31:0] d,
                                input bit df, input logic [1:0] fc, input logic [31:0] fs,
                                input logic [31:0] fa, input logic [3:0] dn);
        bit wr, clr, fl;
        logic [3:0] w;
        w = a[5:2];
        for (int c = 0; c < 4; c++) begin
            wr  = dw && a[10:8] == 0 && a[1:0] == 0 && a[7:6] == c;
            clr = wr && w == 4'd8 && d == 0;
            fl  = df && fc == c && (fs & 32'h17) != 0;
            if (wr && w == 4'd0 && d[1]) m_flush[c] = 1'b1;
            else if (dn[c])              m_flush[c] = 1'b0;
            if (wr) begin
                case (w)
                    4'd0: m_reg[c][0] = d & 32'h0003_003D;
                    4'd2, 4'd3, 4'd4, 4'd6, 4'd10, 4'd11: m_reg[c][w] = d;
                    4'd5, 4'd7: m_reg[c][w] = d & 32'hFF;
                    default: ;
                endcase
            end
            if (fl) begin
                if (m_reg[c][8] == 0 || clr) begin
                    m_reg[c][8]  = fs & 32'h3717;
                    m_reg[c][12] = fa;
                end else begin
                    m_reg[c][8] = m_reg[c][8] | (fs & 32'h17);
                end
            end else if (clr) begin
                m_reg[c][8]  = 0;
                m_reg[c][12] = 0;
            end
        end
    endtask

    task automatic step(input bit dw, input logic [11:0] a, input logic [31:0] d,
                        input bit df, input logic [1:0] fc, input logic [31:0] fs,
                        input logic [31:0] fa, input logic [3:0] dn);
        @(negedge clk);
        wr_en = dw; addr = a; wdata = d;
        flt_valid = df; flt_ctx = fc; flt_status = fs; flt_addr = fa; inv_done = dn;
        model_update(dw, a, d, df, fc, fs, fa, dn);
        @(negedge clk);
        wr_en = 1'b0; flt_valid = 1'b0; inv_done = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 2'd0, 32'h0, 32'h0, 4'h0);
    endtask

    task automatic chk_rd(input logic [11:0] a, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata, exp_rd(a), req);
    endtask

    task automatic chk_out(input string req);
        chk({27'b0, irq, ctx_irq}, {27'b0, |exp_cirq(), exp_cirq()}, {req, " irq"});
        chk({28'b0, inv_req}, {28'b0, exp_inv()}, {req, " inv_req"});
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [3:0] wl [14];
        seed = $urandom(32'h5eed);
        wl = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11, 4'd12, 4'd1, 4'd9, 4'd13};
        for (int c = 0; c < 4; c++) begin
            m_flush[c] = 1'b0;
            for (int w = 0; w < 16; w++) m_reg[c][w] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_out("R1");
        chk_rd(12'h0C0, "R1 ctl");
        chk_rd(12'h0E0, "R1 sts");
        chk_rd(12'h0F0, "R1 far");
        chk(rdata, 32'h0, "R1 far literal");

        // R2: alias and unmapped decode
        wr(12'h050, 32'hA5A5_1234);
        chk_rd(12'h850, "R2 alias");
        chk(rdata, 32'hA5A5_1234, "R2 alias literal");
        wr(12'h150, 32'hFFFF_FFFF);
        chk_rd(12'h150, "R2 unmapped");
        chk_rd(12'h050, "R2 hole write ignored");
        chk_rd(12'h074, "R2 unused offset");

        // R3: control field mask
        wr(12'h000, 32'hFFFF_FFFD);
        chk_rd(12'h000, "R3 ctl mask");
        chk(rdata, 32'h0003_003D, "R3 ctl literal");

        // R10: 40-bit base, read-only fault address
        wr(12'h014, 32'hFFFF_FFFF);
        chk_rd(12'h014, "R10 base hi");
        chk(rdata, 32'h0000_00FF, "R10 base hi literal");
        wr(12'h030, 32'h1234_5678);
        chk_rd(12'h030, "R10 far read-only");

        // R4: flush held until done
        wr(12'h080, 32'h0000_0007);
        chk_out("R4 raise");
        chk_rd(12'h080, "R4 flush reads 1");
        repeat (3) step(1'b0, 12'h0, 0, 1'b0, 0, 0, 0, 4'h0);
        wr(12'h080, 32'h0000_0005);
        chk_out("R4 hold");
        step(1'b0, 12'h0, 0, 1'b0, 0, 0, 0, 4'b0100);
        chk_out("R4 done");
        chk_rd(12'h080, "R4 flush cleared");

        // R5 and R11: done and new flush in the same cycle; flush-only write disables
        wr(12'h080, 32'h0000_0003);
        step(1'b1, 12'h080, 32'h0000_0002, 1'b0, 0, 0, 0, 4'b0100);
        chk_out("R5 collision");
        chk_rd(12'h080, "R11 disabled with flush");
        chk(rdata, 32'h0000_0002, "R11 literal");
        step(1'b0, 12'h0, 0, 1'b0, 0, 0, 0, 4'b0100);
        chk_out("R5 later done");

        // R6: first fault capture
        wr(12'h040, 32'h0000_0004);
        step(1'b0, 12'h0, 0, 1'b1, 2'd1, 32'hFFFF_2402, 32'hDEAD_0000, 4'h0);
        chk_rd(12'h060, "R6 status");
        chk(rdata, 32'h0000_2402, "R6 status literal");
        chk_rd(12'h070, "R6 far");
        chk_out("R9 raised");

        // R7: later fault merges flags only
        step(1'b0, 12'h0, 0, 1'b1, 2'd1, 32'h0000_1511, 32'hBEEF_0000, 4'h0);
        chk_rd(12'h060, "R7 merged");
        chk(rdata, 32'h0000_2413, "R7 literal");
        chk_rd(12'h070, "R7 far kept");

        // R8: nonzero write ignored, zero write clears
        wr(12'h060, 32'h0000_0017);
        chk_rd(12'h060, "R8 nonzero ignored");
        wr(12'h060, 32'h0);
        chk_rd(12'h070, "R8 far zero");
        chk_out("R8 irq drop");

        // R8: zero write and fault together
        step(1'b0, 12'h0, 0, 1'b1, 2'd1, 32'h0000_0001, 32'h1111_0000, 4'h0);
        step(1'b1, 12'h060, 32'h0, 1'b1, 2'd1, 32'h0000_0104, 32'h2222_0000, 4'h0);
        chk_rd(12'h060, "R8 collision status");
        chk_rd(12'h070, "R8 collision far");
        chk(rdata, 32'h2222_0000, "R8 collision literal");

        // R6: fault with no flag bits ignored
        wr(12'h060, 32'h0);
        step(1'b0, 12'h0, 0, 1'b1, 2'd1, 32'h0000_0300, 32'h3333_0000, 4'h0);
        chk_rd(12'h060, "R6 no-flag ignored");

        // R9: interrupt masked when enable clear
        wr(12'h0C0, 32'h0);
        step(1'b0, 12'h0, 0, 1'b1, 2'd3, 32'h0000_0002, 32'h4444_0000, 4'h0);
        chk_out("R9 masked");

        // Random mix of writes, faults and done pulses
        for (int i = 0; i < 600; i++) begin
            logic [11:0] a;
            logic [31:0] d, fs;
            bit dw, df;
            a = {($urandom_range(0, 1) == 1), ($urandom_range(0, 15) == 0) ? 3'b010 : 3'b000,
                 2'($urandom_range(0, 3)), wl[$urandom_range(0, 13)], 2'b00};
            d  = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom();
            dw = ($urandom_range(0, 1) == 1);
            df = ($urandom_range(0, 2) == 0);
            fs = ($urandom_range(0, 4) == 0) ? ($urandom() & 32'h3700) : ($urandom() & 32'h3717);
            step(dw, a, d, df, 2'($urandom_range(0, 3)), fs, $urandom(),
                 4'($urandom_range(0, 15) & $urandom_range(0, 15)));
            chk_out("R4 R7 R9 random");
            chk_rd({1'b0, 3'b000, 2'($urandom_range(0, 3)), wl[$urandom_range(0, 13)], 2'b00},
                   "R6 R8 R10 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule